// File: doc/BRIEF.md
# DMA Channel Address Sequencer with Block Reload

This block holds the address and count sequencing for a single DMA channel. Software writes a base source address, a base destination address, a total transfer count, a block reload setting, a control word and a master enable through a simple register write port. After that, each request from the requester issues exactly one transfer. The transfer presents the current working source and destination addresses on the outputs. The working addresses then step forward, and the counters move down by one.

In reload mode, the block counter reaches the end of each programmed block and the working addresses jump back to the base addresses in the same cycle. The block counter takes its period value again at that point. A fixed memory window is therefore walked over and over while the total count keeps falling. The channel stops when the total count is used up, when either enable is removed, or when a non-maskable stop arrives. It also stops when the half-way flag and the end flag are both set and software has not cleared them. Bus timing, arbitration and the data path belong to other blocks.

Top module: `dma_reload_seq`

## Requirements
- R1: Reset leaves `xfer_valid`, `half_flag`, `end_flag` and `irq` all at 0.
- R2: A request accepted at a clock edge gives `xfer_valid`=1 for one cycle after that edge, with `xfer_src`/`xfer_dst` equal to the working addresses. Both working addresses then advance by `XFER_BYTES`. Writing a base address (select 0 = source, select 1 = destination) also loads the matching working address.
- R3: With mode field (control bits 2:0) equal to 3'b011, a transfer made while the block count is 1 or 0 restores both working addresses from the bases in the same cycle, so the next transfer uses the bases. The same transfer reloads the block count from the period. Select 3 writes the period from bits 23:16 and the block count from bits 7:0. In other cases the block count falls by one.
- R4: With any other mode field value, no restore happens and the addresses keep advancing past the block length.
- R5: Select 2 writes the total count. Each transfer decrements it, and the transfer that brings it to 0 sets `end_flag`. No transfer is issued while the total count is 0.
- R6: `irq` is 1 exactly while `end_flag` is 1 and the interrupt enable (control bit 4) is 1.
- R7: `half_flag` is set by the transfer that brings the total count to the programmed starting value divided by two, rounded down.
- R8: Requests are ignored while the channel enable (control bit 3) or the master enable (select 5, bit 0) is 0.
- R9: A request in a cycle with `nmi`=1 is ignored. The stop latches, and requests stay ignored until a control write with bit 5 = 1.
- R10: While `half_flag` and `end_flag` are both 1, requests are ignored even after a new nonzero total count is written. A control write with bit 5 = 1 clears both flags (and the R9 stop), and transfers then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 base src, 1 base dst, 2 total, 3 reload, 4 control, 5 master) |
| wr_data | input | 32 | Register write data |
| req | input | 1 | Transfer request |
| nmi | input | 1 | Non-maskable stop |
| xfer_valid | output | 1 | One transfer issued this cycle |
| xfer_src | output | ADDR_W | Source address of the transfer |
| xfer_dst | output | ADDR_W | Destination address of the transfer |
| half_flag | output | 1 | Half of the total count done |
| end_flag | output | 1 | Total count exhausted |
| irq | output | 1 | End interrupt |

## Verification
The block restore and the final transfer of the total count can fall on the same clock edge. The half-way flag can also land on a block boundary. The bench programs a total that is a whole multiple of the block period to force these together. A reference model in a scoreboard predicts every address pair, so a restore that arrives a cycle late, or is lost when the end flag sets, shows up as an address miscompare. Checks of `end_flag`, `half_flag` and `irq`, plus an ignored follow-up request, confirm that the counting side settled correctly at the same edge.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;
   localparam logic [2:0] SEL_BSRC   = 3'd0;
   localparam logic [2:0] SEL_BDST   = 3'd1;
   localparam logic [2:0] SEL_TOTAL  = 3'd2;
   localparam logic [2:0] SEL_RELOAD = 3'd3;
   localparam logic [2:0] SEL_CTRL   = 3'd4;
   localparam logic [2:0] SEL_MASTER = 3'd5;

   localparam logic [2:0] MODE_RELOAD = 3'b011;

   localparam int CTRL_EN_BIT  = 3;
   localparam int CTRL_IE_BIT  = 4;
   localparam int CTRL_CLR_BIT = 5;

   localparam int PERIOD_LSB = 16;
   localparam int BLOCK_LSB  = 0;

   typedef struct packed {
      logic [2:0] mode;
      logic       ch_en;
      logic       ie;
   } ctrl_t;
endpackage

// File: rtl/dma_rl_addr.sv
module dma_rl_addr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              adv,
   input  logic              rew,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] work_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o <= '0;
         work_o <= '0;
      end else if (ld) begin
         base_o <= ld_val;
         work_o <= ld_val;
      end else if (rew) begin
         work_o <= base_o;
      end else if (adv) begin
         work_o <= work_o + STEP_V;
      end
   end
endmodule

// File: rtl/dma_rl_count.sv
module dma_rl_count #(
   parameter int TOT_W = 24,
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_tot,
   input  logic             ld_rel,
   input  logic [31:0]      wdata,
   input  logic             step,
   input  logic             reload_mode,
   input  logic             clr,
   output logic [TOT_W-1:0] tot_o,
   output logic [BLK_W-1:0] blk_o,
   output logic [BLK_W-1:0] per_o,
   output logic             wrap_o,
   output logic             half_o,
   output logic             end_o
);
   import dma_rl_pkg::*;

   localparam logic [TOT_W-1:0] ONE_T = TOT_W'(1);
   localparam logic [BLK_W-1:0] ONE_B = BLK_W'(1);

   logic [TOT_W-1:0] start_q;
   logic [TOT_W-1:0] tot_next;

   assign tot_next = tot_o - ONE_T;
   assign wrap_o   = reload_mode && (blk_o <= ONE_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_o   <= '0;
         start_q <= '0;
      end else if (ld_tot) begin
         tot_o   <= wdata[TOT_W-1:0];
         start_q <= wdata[TOT_W-1:0];
      end else if (step) begin
         tot_o <= tot_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_o <= '0;
         per_o <= '0;
      end else if (ld_rel) begin
         per_o <= wdata[PERIOD_LSB +: BLK_W];
         blk_o <= wdata[BLOCK_LSB +: BLK_W];
      end else if (step) begin
         if (wrap_o)           blk_o <= per_o;
         else if (blk_o != '0) blk_o <= blk_o - ONE_B;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_o <= 1'b0;
         end_o  <= 1'b0;
      end else if (clr) begin
         half_o <= 1'b0;
         end_o  <= 1'b0;
      end else if (step) begin
         if (tot_next == (start_q >> 1)) half_o <= 1'b1;
         if (tot_next == '0)             end_o  <= 1'b1;
      end
   end
endmodule

// File: rtl/dma_reload_seq.sv
module dma_reload_seq #(
   parameter int ADDR_W     = 32,
   parameter int TOT_W      = 24,
   parameter int BLK_W      = 8,
   parameter int XFER_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              req,
   input  logic              nmi,
   output logic              xfer_valid,
   output logic [ADDR_W-1:0] xfer_src,
   output logic [ADDR_W-1:0] xfer_dst,
   output logic              half_flag,
   output logic              end_flag,
   output logic              irq
);
   import dma_rl_pkg::*;

   localparam int NUM_PTR = 2;

   generate
      if (BLK_W < 1 || BLK_W > 8)       $error("BLK_W must be 1..8");
      if (TOT_W < 2 || TOT_W > 32)      $error("TOT_W must be 2..32");
      if (ADDR_W < 8 || ADDR_W > 32)    $error("ADDR_W must be 8..32");
      if (XFER_BYTES < 1)               $error("XFER_BYTES must be positive");
   endgenerate

   ctrl_t ctrl_q;
   logic  me_q;
   logic  nmi_q;
   logic  go;
   logic  wrap;
   logic  clr;

   logic [TOT_W-1:0]  tot_q;
   logic [BLK_W-1:0]  blk_q;
   logic [BLK_W-1:0]  per_q;
   logic [ADDR_W-1:0] base_a [NUM_PTR];
   logic [ADDR_W-1:0] work_a [NUM_PTR];

   assign clr = wr_en && (wr_sel == SEL_CTRL) && wr_data[CTRL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         me_q   <= 1'b0;
         nmi_q  <= 1'b0;
      end else begin
         if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl_q.mode  <= wr_data[2:0];
            ctrl_q.ch_en <= wr_data[CTRL_EN_BIT];
            ctrl_q.ie    <= wr_data[CTRL_IE_BIT];
         end
         if (wr_en && wr_sel == SEL_MASTER) me_q <= wr_data[0];
         if (clr)      nmi_q <= 1'b0;
         else if (nmi) nmi_q <= 1'b1;
      end
   end

   assign go = req && ctrl_q.ch_en && me_q && !nmi && !nmi_q &&
               (tot_q != '0) && !(half_flag && end_flag);

   generate
      for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
         localparam logic [2:0] MY_SEL = (g == 0) ? SEL_BSRC : SEL_BDST;
         dma_rl_addr #(.ADDR_W(ADDR_W), .STEP(XFER_BYTES)) u_addr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_en && wr_sel == MY_SEL),
            .ld_val (wr_data[ADDR_W-1:0]),
            .adv    (go && !wrap),
            .rew    (go && wrap),
            .base_o (base_a[g]),
            .work_o (work_a[g])
         );
      end
   endgenerate

   dma_rl_count #(.TOT_W(TOT_W), .BLK_W(BLK_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_tot      (wr_en && wr_sel == SEL_TOTAL),
      .ld_rel      (wr_en && wr_sel == SEL_RELOAD),
      .wdata       (wr_data),
      .step        (go),
      .reload_mode (ctrl_q.mode == MODE_RELOAD),
      .clr         (clr),
      .tot_o       (tot_q),
      .blk_o       (blk_q),
      .per_o       (per_q),
      .wrap_o      (wrap),
      .half_o      (half_flag),
      .end_o       (end_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_valid <= 1'b0;
         xfer_src   <= '0;
         xfer_dst   <= '0;
      end else begin
         xfer_valid <= go;
         if (go) begin
            xfer_src <= work_a[0];
            xfer_dst <= work_a[1];
         end
      end
   end

   assign irq = end_flag && ctrl_q.ie;
endmodule

// File: rtl/dma_reload_seq_chk.sv
module dma_reload_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int TOT_W  = 24,
   parameter int BLK_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              req,
   input logic              nmi,
   input logic              go,
   input logic              wrap,
   input logic              ch_en,
   input logic              me,
   input logic              xfer_valid,
   input logic              half_flag,
   input logic              end_flag,
   input logic              irq,
   input logic [TOT_W-1:0]  tot_q,
   input logic [BLK_W-1:0]  blk_q,
   input logic [BLK_W-1:0]  per_q,
   input logic [ADDR_W-1:0] base_src,
   input logic [ADDR_W-1:0] base_dst,
   input logic [ADDR_W-1:0] work_src,
   input logic [ADDR_W-1:0] work_dst
);
   a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> $past(req));

   a_r3_rewind_to_base: assert property (@(posedge clk) disable iff (!rst_n)
      (go && wrap && !wr_en) |=> (work_src == base_src && work_dst == base_dst && blk_q == per_q));

   a_r5_zero_total_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_q == '0) |=> !xfer_valid);

   a_r6_irq_from_end: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> end_flag);

   a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_en && me) |=> !xfer_valid);

   a_r9_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !xfer_valid);

   a_r10_both_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (half_flag && end_flag) |=> !xfer_valid);
endmodule

bind dma_reload_seq dma_reload_seq_chk #(.ADDR_W(ADDR_W), .TOT_W(TOT_W), .BLK_W(BLK_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .req        (req),
   .nmi        (nmi),
   .go         (go),
   .wrap       (wrap),
   .ch_en      (ctrl_q.ch_en),
   .me         (me_q),
   .xfer_valid (xfer_valid),
   .half_flag  (half_flag),
   .end_flag   (end_flag),
   .irq        (irq),
   .tot_q      (tot_q),
   .blk_q      (blk_q),
   .per_q      (per_q),
   .base_src   (base_a[0]),
   .base_dst   (base_a[1]),
   .work_src   (work_a[0]),
   .work_dst   (work_a[1])
);

// File: tb/dma_reload_seq_tb_top.sv
module dma_reload_seq_tb_top;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic          req = 1'b0;
   logic          nmi = 1'b0;
   logic          xfer_valid;
   logic [AW-1:0] xfer_src, xfer_dst;
   logic          half_flag, end_flag, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [63:0] exp_q [$];
   string       tag_q [$];

   // reference model state
   logic [31:0] m_src, m_dst, m_bsrc, m_bdst;
   int  m_blk, m_per, m_tot, m_start;
   bit  m_half, m_end, m_nmi, m_ch, m_me, m_rel;

   always #4 clk = ~clk;

   dma_reload_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req(req), .nmi(nmi), .xfer_valid(xfer_valid), .xfer_src(xfer_src),
      .xfer_dst(xfer_dst), .half_flag(half_flag), .end_flag(end_flag), .irq(irq)
   );

   task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && xfer_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2 unexpected transfer: actual %h/%h expected none", xfer_src, xfer_dst);
         end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_eq(t, "transfer src", xfer_src, e[63:32]);
            check_eq(t, "transfer dst", xfer_dst, e[31:0]);
         end
      end
   end

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         3'd0: begin m_bsrc = data; m_src = data; end
         3'd1: begin m_bdst = data; m_dst = data; end
         3'd2: begin m_tot = int'(data[23:0]); m_start = m_tot; end
         3'd3: begin m_per = int'(data[23:16]); m_blk = int'(data[7:0]); end
         3'd4: begin
            m_rel = (data[2:0] == 3'b011);
            m_ch  = data[3];
            if (data[5]) begin m_half = 0; m_end = 0; m_nmi = 0; end
         end
         3'd5: m_me = data[0];
         default: ;
      endcase
   endtask

   // driver: one request, predicted result pushed to the scoreboard
   task automatic do_req(input bit with_nmi, input string tag);
      bit go, wrap;
      @(negedge clk);
      req = 1'b1; nmi = with_nmi;
      go = m_ch && m_me && !with_nmi && !m_nmi && (m_tot != 0) && !(m_half && m_end);
      if (go) begin
         exp_q.push_back({m_src, m_dst});
         tag_q.push_back(tag);
         wrap = m_rel && (m_blk <= 1);
         if (wrap) begin m_src = m_bsrc; m_dst = m_bdst; m_blk = m_per; end
         else begin m_src += 4; m_dst += 4; if (m_blk != 0) m_blk--; end
         m_tot--;
         if (m_tot == m_start / 2) m_half = 1;
         if (m_tot == 0) m_end = 1;
      end
      if (with_nmi) m_nmi = 1;
      @(negedge clk);
      req = 1'b0; nmi = 1'b0;
      if (!go) check_eq(tag, "request ignored, xfer_valid", {31'd0, xfer_valid}, 32'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      m_src = 0; m_dst = 0; m_bsrc = 0; m_bdst = 0;
      m_blk = 0; m_per = 0; m_tot = 0; m_start = 0;
      m_half = 0; m_end = 0; m_nmi = 0; m_ch = 0; m_me = 0; m_rel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_eq("R1", "xfer_valid", {31'd0, xfer_valid}, 0);
      check_eq("R1", "half_flag", {31'd0, half_flag}, 0);
      check_eq("R1", "end_flag", {31'd0, end_flag}, 0);
      check_eq("R1", "irq", {31'd0, irq}, 0);

      // R3 reload mode: block 4, total 10
      wr(3'd0, 32'h0000_1000);
      wr(3'd1, 32'h0000_8000);
      wr(3'd3, (32'd4 << 16) | 32'd4);
      wr(3'd2, 32'd10);
      wr(3'd5, 32'd1);
      wr(3'd4, 32'h03 | 32'h08 | 32'h10);
      for (int i = 0; i < 10; i++) begin
         do_req(0, "R3");
         if (i == 3) check_eq("R7", "half_flag before half", {31'd0, half_flag}, 0);
         if (i == 4) check_eq("R7", "half_flag at half", {31'd0, half_flag}, 1);
         if (i == 8) check_eq("R5", "end_flag early", {31'd0, end_flag}, 0);
      end
      check_eq("R5", "end_flag", {31'd0, end_flag}, 1);
      check_eq("R6", "irq", {31'd0, irq}, 1);
      do_req(0, "R5");

      // clear, then block boundary and end on the same edge (total 8, block 4)
      wr(3'd4, 32'h03 | 32'h08 | 32'h10 | 32'h20);
      check_eq("R6", "irq after clear", {31'd0, irq}, 0);
      wr(3'd3, (32'd4 << 16) | 32'd4);
      wr(3'd2, 32'd8);
      for (int i = 0; i < 8; i++) do_req(0, "R3");
      check_eq("R5", "end_flag with reload", {31'd0, end_flag}, 1);
      check_eq("R7", "half_flag with reload", {31'd0, half_flag}, 1);

      // R10 both flags hold the channel
      wr(3'd2, 32'd3);
      do_req(0, "R10");
      wr(3'd4, 32'h03 | 32'h08 | 32'h10 | 32'h20);
      do_req(0, "R10");

      // R4 normal mode, addresses run past the block length
      wr(3'd4, 32'h00 | 32'h08 | 32'h10 | 32'h20);
      wr(3'd0, 32'h0000_2000);
      wr(3'd1, 32'h0000_9000);
      wr(3'd3, (32'd2 << 16) | 32'd2);
      wr(3'd2, 32'd6);
      for (int i = 0; i < 6; i++) do_req(0, "R4");
      check_eq("R6", "irq with ie", {31'd0, irq}, 1);
      wr(3'd4, 32'h00 | 32'h08 | 32'h20);

      // R8 enables
      wr(3'd4, 32'h03 | 32'h10 | 32'h20);
      wr(3'd2, 32'd4);
      do_req(0, "R8");
      wr(3'd4, 32'h03 | 32'h08 | 32'h10);
      wr(3'd5, 32'd0);
      do_req(0, "R8");
      wr(3'd5, 32'd1);
      do_req(0, "R8");

      // R9 nmi stop latches until clear
      do_req(1, "R9");
      do_req(0, "R9");
      wr(3'd4, 32'h03 | 32'h08 | 32'h10 | 32'h20);
      do_req(0, "R9");

      repeat (3) @(negedge clk);
      check_eq("R2", "scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule